// File: doc/BRIEF.md
# Two-Bank Skewed Cache Tag Lookup and Victim Selection

This block decides, for each load, whether the addressed line is present in a two-way skewed-associative data cache. Its two banks are the same size and are probed in the same cycle, but each bank reaches its line through a different XOR hash of two address fields. As a result, addresses that collide in one bank are usually spread over different lines of the other. The block stores the tags and valid bits of both banks. It reports a hit and the bank that hit, or else it reports a miss together with the bank and the line index that should take the refill.

Replacement uses one recency bit per line, and only bank 0 lines have it. A hit or a refill in bank 0 sets the bit. A hit or a refill in bank 1 clears the bit of the bank 0 line that the same address selects. On a miss, that bit chooses the bank that receives the new line. An empty candidate line is always preferred.

The surrounding cache is write-through and does not allocate on writes, so only loads reach this block. Once the line has been fetched, the outer controller signals the refill and passes back the address and the chosen bank. Data storage and the memory interface belong to the surrounding logic.

Top module: `skew_lookup_ctrl`

## Requirements
- R1: A request in one cycle produces a result with `rsp_valid` high in the next cycle and only in that cycle. In a cycle with no request in the previous cycle, every output is zero.
- R2: Let A1 be `addr[OFF_W+IDX_W-1:OFF_W]` and A2 be the next IDX_W bits above it; by default these are bits 11:5 and bits 18:12. Let T be the mask that has every odd-numbered bit set. The bank 0 index is (A2 AND T) XOR A1, and the bank 1 index is (A2 AND NOT T) XOR A1. `rsp_vict_idx` gives the victim line in the index space of its own bank.
- R3: The tag is `addr[ADDR_W-1:OFF_W]`. A bank hits when its line at that bank's index is valid and holds an equal tag. A hit gives `rsp_hit`=1 and `rsp_hit_bank` (0 = bank 0, 1 = bank 1). If both banks hit, bank 0 is reported.
- R4: After reset every line is invalid, every recency bit is clear, and all outputs are zero.
- R5: A hit in bank 0 sets the recency bit at the bank 0 index. A hit in bank 1 clears it. A miss leaves the bit unchanged.
- R6: On a miss where both candidate lines are valid, a set recency bit selects bank 1 as the victim and a clear bit selects bank 0.
- R7: On a miss where exactly one candidate line is invalid, that line is the victim whatever the recency bit holds. When both candidates are invalid, R6 decides.
- R8: A refill (`fill_valid` with `fill_addr` and `fill_bank`) writes the tag into the chosen bank at that bank's index of `fill_addr` and marks the line valid. A bank 0 refill sets the recency bit at the bank 0 index of `fill_addr`, and a bank 1 refill clears it.
- R9: A lookup in the same cycle as a refill sees the contents from before that refill. Where both write the same recency bit, the refill's value is kept.
- R10: On a hit the victim fields read zero. On a miss `rsp_hit_bank` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load lookup request |
| req_addr | input | ADDR_W | Load byte address |
| fill_valid | input | 1 | Refill complete, write the line |
| fill_addr | input | ADDR_W | Address of the refilled line |
| fill_bank | input | 1 | Bank receiving the refill |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_hit_bank | output | 1 | Bank that hit |
| rsp_vict_bank | output | 1 | Bank chosen for the refill on a miss |
| rsp_vict_idx | output | LINE_LOG-1 | Line index of the victim in its bank |

## Verification
Every lookup result is registered once, so a request driven before clock edge E produces its result on the outputs just after E. The bench drives each request half a cycle before E and compares all five result outputs at the falling edge that follows E. Refill writes and recency updates also take effect at E, so the reference model applies them after computing the expected result for that same cycle. This is how it predicts the R9 ordering. The lookup that follows then sees the updated state one cycle later, just as the design does.

// File: rtl/skew_pkg.sv
package skew_pkg;

    typedef enum logic {
        BANK0 = 1'b0,
        BANK1 = 1'b1
    } bank_e;

    // Mask with every odd-numbered bit set, limited to the given width.
    function automatic logic [31:0] alt_mask(input int width);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if ((i < width) && ((i % 2) == 1)) begin
                m[i] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/skew_index_hash.sv
module skew_index_hash #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int IDX_W  = 7
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic [IDX_W-1:0]        idx0,
    output logic [IDX_W-1:0]        idx1,
    output logic [ADDR_W-OFF_W-1:0] tag
);
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam logic [IDX_W-1:0] MASK = IDX_W'(skew_pkg::alt_mask(IDX_W));

    logic [IDX_W-1:0] fld_lo;
    logic [IDX_W-1:0] fld_hi;
    logic             unused_off;

    always_comb begin
        fld_lo     = addr[OFF_W +: IDX_W];
        fld_hi     = addr[OFF_W + IDX_W +: IDX_W];
        idx0       = (fld_hi & MASK) ^ fld_lo;
        idx1       = (fld_hi & ~MASK) ^ fld_lo;
        tag        = addr[ADDR_W-1 -: TAG_W];
        unused_off = ^addr[OFF_W-1:0];
    end

    // R2: the two bank indices always differ exactly by the upper field
    always_comb begin
        if (!$isunknown(addr)) begin
            a_r2_index_pair: assert ((idx0 ^ idx1) == fld_hi);
        end
    end

endmodule

// File: rtl/skew_tag_bank.sv
module skew_tag_bank #(
    parameter int IDX_W = 7,
    parameter int TAG_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0] tag_d [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    always_comb begin
        valid_d = valid_q;
        for (int i = 0; i < LINES; i++) begin
            tag_d[i] = tag_q[i];
        end
        if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
            tag_d[wr_idx]   = wr_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            tag_q[i] <= tag_d[i];
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
    end

    // R8: a written line is valid and holds the written tag on the next cycle
    a_r8_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))));

endmodule

// File: rtl/skew_lru_flags.sv
module skew_lru_flags #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_flag,
    input  logic             lk_en,
    input  logic             lk_val,
    input  logic             fl_en,
    input  logic [IDX_W-1:0] fl_idx,
    input  logic             fl_val
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (lk_en) begin
            flag_d[lk_idx] = lk_val;
        end
        // refill is applied last so it wins on a shared line
        if (fl_en) begin
            flag_d[fl_idx] = fl_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign lk_flag = flag_q[lk_idx];

    // R9: a refill's recency value always survives
    a_r9_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fl_en |=> (flag_q[$past(fl_idx)] == $past(fl_val)));

    // R5: a lookup update lands when no refill targets the same bit
    a_r5_hit_update: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && !(fl_en && (fl_idx == lk_idx))) |=> (flag_q[$past(lk_idx)] == $past(lk_val)));

endmodule

// File: rtl/skew_victim_pick.sv
module skew_victim_pick #(
    parameter int IDX_W = 7
) (
    input  logic             line0_valid,
    input  logic             line1_valid,
    input  logic             recent0,
    input  logic [IDX_W-1:0] idx0,
    input  logic [IDX_W-1:0] idx1,
    output skew_pkg::bank_e  vict_bank,
    output logic [IDX_W-1:0] vict_idx
);
    import skew_pkg::*;

    always_comb begin
        if (line0_valid && !line1_valid) begin
            vict_bank = BANK1;
        end else if (!line0_valid && line1_valid) begin
            vict_bank = BANK0;
        end else if (recent0) begin
            vict_bank = BANK1;
        end else begin
            vict_bank = BANK0;
        end
        vict_idx = (vict_bank == BANK1) ? idx1 : idx0;
    end

endmodule

// File: rtl/skew_lookup_ctrl.sv
module skew_lookup_ctrl #(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 5,
    parameter int LINE_LOG = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  fill_valid,
    input  logic [ADDR_W-1:0]     fill_addr,
    input  logic                  fill_bank,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic                  rsp_hit_bank,
    output logic                  rsp_vict_bank,
    output logic [LINE_LOG-2:0]   rsp_vict_idx
);
    import skew_pkg::*;

    localparam int IDX_W  = LINE_LOG - 1;
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int NBANKS = 2;

    typedef struct packed {
        logic             valid;
        logic             hit;
        bank_e            hit_bank;
        bank_e            vict_bank;
        logic [IDX_W-1:0] vict_idx;
    } resp_t;

    resp_t resp_d, resp_q;

    logic [IDX_W-1:0] rq_idx [NBANKS];
    logic [IDX_W-1:0] fl_idx [NBANKS];
    logic [TAG_W-1:0] rq_tag;
    logic [TAG_W-1:0] fl_tag;
    logic             ln_valid [NBANKS];
    logic [TAG_W-1:0] ln_tag   [NBANKS];
    logic             ln_hit   [NBANKS];
    logic             recent0;
    logic             any_hit;
    bank_e            pick_bank;
    logic [IDX_W-1:0] pick_idx;

    skew_index_hash #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_req_hash (
        .addr (req_addr),
        .idx0 (rq_idx[0]),
        .idx1 (rq_idx[1]),
        .tag  (rq_tag)
    );

    skew_index_hash #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_fill_hash (
        .addr (fill_addr),
        .idx0 (fl_idx[0]),
        .idx1 (fl_idx[1]),
        .tag  (fl_tag)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        skew_tag_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (rq_idx[b]),
            .rd_valid (ln_valid[b]),
            .rd_tag   (ln_tag[b]),
            .wr_en    (fill_valid && (fill_bank == 1'(b))),
            .wr_idx   (fl_idx[b]),
            .wr_tag   (fl_tag)
        );
        assign ln_hit[b] = ln_valid[b] && (ln_tag[b] == rq_tag);
    end

    assign any_hit = ln_hit[0] || ln_hit[1];

    skew_lru_flags #(.IDX_W(IDX_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_idx  (rq_idx[0]),
        .lk_flag (recent0),
        .lk_en   (req_valid && any_hit),
        .lk_val  (ln_hit[0]),
        .fl_en   (fill_valid),
        .fl_idx  (fl_idx[0]),
        .fl_val  (fill_bank == 1'b0)
    );

    skew_victim_pick #(.IDX_W(IDX_W)) u_pick (
        .line0_valid (ln_valid[0]),
        .line1_valid (ln_valid[1]),
        .recent0     (recent0),
        .idx0        (rq_idx[0]),
        .idx1        (rq_idx[1]),
        .vict_bank   (pick_bank),
        .vict_idx    (pick_idx)
    );

    always_comb begin
        resp_d = '0;
        if (req_valid) begin
            resp_d.valid = 1'b1;
            if (ln_hit[0]) begin
                resp_d.hit      = 1'b1;
                resp_d.hit_bank = BANK0;
            end else if (ln_hit[1]) begin
                resp_d.hit      = 1'b1;
                resp_d.hit_bank = BANK1;
            end else begin
                resp_d.vict_bank = pick_bank;
                resp_d.vict_idx  = pick_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rsp_valid     = resp_q.valid;
    assign rsp_hit       = resp_q.hit;
    assign rsp_hit_bank  = resp_q.hit_bank;
    assign rsp_vict_bank = resp_q.vict_bank;
    assign rsp_vict_idx  = resp_q.vict_idx;

    // R1: a result appears exactly one cycle after each request
    a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(req_valid)));

    // R10: a hit leaves the victim fields at zero
    a_r10_hit_no_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (!rsp_vict_bank && (rsp_vict_idx == '0)));

    // R1: nothing is reported without a request
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_hit_bank && !rsp_vict_bank));

endmodule

// File: tb/sim_skew_lookup_ctrl.sv
`timescale 1ns/1ps
module sim_skew_lookup_ctrl;
    localparam int AW = 32;
    localparam int OW = 5;
    localparam int IW = 7;
    localparam int TW = AW - OW;
    localparam int NL = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic          fill_bank = 1'b0;
    logic          rsp_valid, rsp_hit, rsp_hit_bank, rsp_vict_bank;
    logic [IW-1:0] rsp_vict_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    bit            mv [2][NL];
    logic [TW-1:0] mt [2][NL];
    bit            mf [NL];
    logic          e_valid, e_hit, e_hbank, e_vbank;
    logic [IW-1:0] e_vidx;

    always #2 clk = ~clk;

    skew_lookup_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_bank(fill_bank),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hit_bank(rsp_hit_bank),
        .rsp_vict_bank(rsp_vict_bank), .rsp_vict_idx(rsp_vict_idx)
    );

    function automatic logic [IW-1:0] odd_mask();
        logic [IW-1:0] m = '0;
        for (int i = 1; i < IW; i += 2) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [IW-1:0] bank_index(input logic [AW-1:0] a, input int bank);
        logic [IW-1:0] lo = IW'(a >> OW);
        logic [IW-1:0] hi = IW'(a >> (OW + IW));
        return (bank == 0) ? ((hi & odd_mask()) ^ lo) : ((hi & ~odd_mask()) ^ lo);
    endfunction

    task automatic model_clear();
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < NL; i++) begin
                mv[b][i] = 0;
                mt[b][i] = '0;
            end
        for (int i = 0; i < NL; i++) mf[i] = 0;
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_hit_bank !== e_hbank ||
            rsp_vict_bank !== e_vbank || rsp_vict_idx !== e_vidx) begin
            n_bad++;
            $display("FAIL %s: got v=%b h=%b hb=%b vb=%b vi=%0d, expected v=%b h=%b hb=%b vb=%b vi=%0d",
                     tag, rsp_valid, rsp_hit, rsp_hit_bank, rsp_vict_bank, rsp_vict_idx,
                     e_valid, e_hit, e_hbank, e_vbank, e_vidx);
        end
    endtask

    // one cycle: drive at a falling edge, predict, compare at the next falling edge
    task automatic step(input logic rv, input logic [AW-1:0] ra,
                        input logic fv, input logic [AW-1:0] fa, input logic fb,
                        input string tag);
        logic [IW-1:0] i0, i1;
        logic [TW-1:0] t;
        bit h0, h1;
        req_valid  = rv;
        req_addr   = ra;
        fill_valid = fv;
        fill_addr  = fa;
        fill_bank  = fb;
        e_valid = 0; e_hit = 0; e_hbank = 0; e_vbank = 0; e_vidx = '0;
        if (rv) begin
            i0 = bank_index(ra, 0);
            i1 = bank_index(ra, 1);
            t  = ra[AW-1:OW];
            h0 = mv[0][i0] && (mt[0][i0] == t);
            h1 = mv[1][i1] && (mt[1][i1] == t);
            e_valid = 1;
            if (h0) begin
                e_hit = 1; e_hbank = 0; mf[i0] = 1;
            end else if (h1) begin
                e_hit = 1; e_hbank = 1; mf[i0] = 0;
            end else begin
                if (mv[0][i0] && !mv[1][i1])      e_vbank = 1;
                else if (!mv[0][i0] && mv[1][i1]) e_vbank = 0;
                else                              e_vbank = mf[i0];
                e_vidx = e_vbank ? i1 : i0;
            end
        end
        if (fv) begin
            i0 = bank_index(fa, 0);
            i1 = bank_index(fa, 1);
            mv[fb][fb ? i1 : i0] = 1;
            mt[fb][fb ? i1 : i0] = fa[AW-1:OW];
            mf[i0] = (fb == 1'b0);
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 0;
        fill_valid = 0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_valid = 0; e_hit = 0; e_hbank = 0; e_vbank = 0; e_vidx = '0;
        compare("R4");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [AW-1:0] a_x, a_y, a_z, a_w;
        logic          pend;
        logic [AW-1:0] pend_addr;
        logic          pend_bank;
        a_x = 32'h0000_00A0;            // A1=5, A2=0
        a_y = 32'h0000_10A0;            // A2 bit0 set: same bank 0 index, other bank 1 index
        a_z = 32'h0008_10A0;            // same indices as a_y, different upper tag
        a_w = 32'h0000_20A0;            // A2 bit1 set: bank 0 index moves, bank 1 index stays
        @(negedge clk);
        do_reset();

        step(0, '0, 0, '0, 0, "R1");
        step(1, a_x, 0, '0, 0, "R7");   // both empty, clear bit -> bank 0
        step(0, '0, 0, '0, 0, "R1");
        step(0, '0, 1, a_x, 0, "R8");
        step(1, a_x, 0, '0, 0, "R3");
        step(1, a_y, 0, '0, 0, "R7");   // bank 1 line empty -> bank 1, index 4
        step(0, '0, 1, a_y, 1, "R8");
        step(1, a_z, 0, '0, 0, "R6");   // both full, bit clear -> bank 0
        step(1, a_x, 0, '0, 0, "R5");
        step(1, a_z, 0, '0, 0, "R6");   // bit set -> bank 1
        step(1, a_y, 0, '0, 0, "R5");
        step(1, a_z, 0, '0, 0, "R5");   // bit cleared again -> bank 0
        step(1, a_x, 1, a_z, 1, "R9");  // hit on old state, refill bit wins
        step(1, a_y, 0, '0, 0, "R9");   // y evicted, bit clear -> bank 0
        step(1, a_z, 0, '0, 0, "R8");
        step(1, a_w, 0, '0, 0, "R2");
        step(1, a_x, 0, '0, 0, "R10");
        do_reset();
        step(1, a_x, 0, '0, 0, "R4");

        // random stream over a small address space, refilling every miss
        pend = 0;
        pend_addr = '0;
        pend_bank = 0;
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] ra;
            logic          rv;
            logic          fv;
            logic [AW-1:0] fa;
            logic          fb;
            ra = (AW'($urandom_range(0, 3)) << 19) | (AW'($urandom_range(0, 7)) << 12) |
                 (AW'($urandom_range(0, 7)) << 5) | AW'($urandom_range(0, 31));
            rv = ($urandom_range(0, 9) != 0);
            fv = pend;
            fa = pend_addr;
            fb = pend_bank;
            pend = 0;
            step(rv, ra, fv, fa, fb, "R3");
            if (e_valid && !e_hit && !fv) begin
                pend = 1;
                pend_addr = ra;
                pend_bank = e_vbank;
            end
        end
        finish_run();
    end

endmodule